// File: doc/BRIEF.md
# Sequential Integer and Fractional Divider

This block divides an unsigned 16-bit dividend by an unsigned 16-bit divisor over many clock cycles. A single-cycle start pulse captures both operands and a mode select. In integer mode the block produces the ordinary quotient and remainder. In fractional mode the dividend is read as a fraction of 2^16, so the quotient is (dividend × 65536) / divisor and the remainder is what is left of that scaled dividend.

The operands come from a double accumulator (dividend) and an index register (divisor). The quotient is meant to go back to the index register and the remainder back to the accumulator. The surrounding processor writes those registers itself. One restoring shift-subtract engine serves both modes and resolves one quotient bit per cycle. The sequencer then idles, so the completion pulse always arrives a fixed 41 cycles after the accepted start. The zero, overflow and carry flags come with the results, each mode following its own flag rules.

Top module: `div_unit`

## Requirements
- R1: In integer mode with a nonzero divisor, the block outputs quotient = dividend / divisor and remainder = dividend mod divisor.
- R2: In fractional mode with divisor > dividend, the block outputs quotient = floor(dividend·65536 / divisor) and remainder = (dividend·65536) mod divisor.
- R3: If a start is accepted on rising edge k, `done` is high for exactly one cycle, starting at edge k+41. `busy` is high from edge k until edge k+41 and low while `done` is high.
- R4: In integer mode, flag_v is always 0 and flag_c is 0 for a nonzero divisor. In both modes, flag_z is 1 exactly when the 16-bit quotient output is 0.
- R5: In fractional mode with a divisor less than or equal to the dividend, flag_v is 1, the quotient is 0xFFFF and the remainder equals the dividend. In fractional mode with divisor > dividend, flag_v is 0.
- R6: A zero divisor in either mode sets flag_c to 1, makes the quotient 0xFFFF and makes the remainder equal the dividend. Any nonzero divisor gives flag_c = 0.
- R7: A start that arrives while `busy` is high is ignored. The operands and mode of the divide in progress are kept, and `done` still arrives 41 cycles after the original start.
- R8: After reset, busy, done, quotient, remainder and all flags are 0. Quotient, remainder and flags change only on the edge that raises `done`, and hold their values until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request, sampled on a rising edge when not busy |
| frac_mode | input | 1 | 0 = integer divide, 1 = fractional divide, captured with start |
| dividend | input | 16 | Dividend (double accumulator value), captured with start |
| divisor | input | 16 | Divisor (index register value), captured with start |
| busy | output | 1 | A divide is in progress |
| done | output | 1 | One-cycle completion pulse; results valid from this cycle |
| quotient | output | 16 | Quotient, destined for the index register |
| remainder | output | 16 | Remainder, destined for the double accumulator |
| flag_z | output | 1 | Quotient is zero |
| flag_v | output | 1 | Fractional overflow (divisor not above dividend) |
| flag_c | output | 1 | Divisor was zero |

## Verification
The assertions assume that reset is asserted before the first clock edge, and that `start`, `frac_mode` and the operands are ordinary synchronous inputs that settle between edges. The checker copies the operands and mode on the same accepted edge that the design uses and judges the flags against those copies. The stimulus changes every input just after a rising edge and holds `start` for a single cycle. It also raises `start` with different operands partway through a divide, to exercise the path where the request is ignored.

// File: rtl/div_pkg.sv
package div_pkg;

  typedef enum logic {
    MODE_INT  = 1'b0,
    MODE_FRAC = 1'b1
  } div_mode_e;

  typedef struct packed {
    logic z;
    logic v;
    logic c;
  } div_flags_t;

endpackage

// File: rtl/div_seq_ctrl.sv
module div_seq_ctrl #(
  parameter int WIDTH   = 16,
  parameter int LATENCY = 41
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic step,
  output logic finish,
  output logic busy,
  output logic done
);

  localparam int CW = $clog2(LATENCY);
  localparam logic [CW-1:0] LAST_CNT = CW'(LATENCY - 1);
  localparam logic [CW-1:0] ITER_CNT = CW'(WIDTH);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;
  logic          done_q, done_d;

  assign load   = start & ~busy_q;
  assign step   = busy_q & (cnt_q < ITER_CNT);
  assign finish = busy_q & (cnt_q == LAST_CNT);

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    done_d = finish;
    if (load) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (busy_q) begin
      if (finish) begin
        busy_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign busy = busy_q;
  assign done = done_q;

endmodule

// File: rtl/div_shift_core.sv
module div_shift_core
  import div_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic             frac_mode,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic [WIDTH-1:0] part_quo,
  output logic [WIDTH-1:0] part_rem,
  output logic [WIDTH-1:0] dvd_hold,
  output logic [WIDTH-1:0] dvs_hold,
  output div_mode_e        mode_hold
);

  logic [WIDTH-1:0] rem_q, rem_d;
  logic [WIDTH-1:0] quo_q, quo_d;
  logic [WIDTH-1:0] dvd_q, dvs_q;
  div_mode_e        mode_q;

  logic [WIDTH:0]   trial;
  logic [WIDTH:0]   diff;
  logic             fits;

  // one restoring iteration: shift in the next dividend bit, try the subtract
  always_comb begin
    trial = {rem_q, quo_q[WIDTH-1]};
    diff  = trial - {1'b0, dvs_q};
    fits  = (trial >= {1'b0, dvs_q});
    rem_d = rem_q;
    quo_d = quo_q;
    if (load) begin
      if (frac_mode) begin
        rem_d = dividend;
        quo_d = '0;
      end else begin
        rem_d = '0;
        quo_d = dividend;
      end
    end else if (step) begin
      rem_d = fits ? diff[WIDTH-1:0] : trial[WIDTH-1:0];
      quo_d = {quo_q[WIDTH-2:0], fits};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
    end else begin
      rem_q <= rem_d;
      quo_q <= quo_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dvd_q  <= '0;
      dvs_q  <= '0;
      mode_q <= MODE_INT;
    end else if (load) begin
      dvd_q  <= dividend;
      dvs_q  <= divisor;
      mode_q <= div_mode_e'(frac_mode);
    end
  end

  assign part_quo  = quo_q;
  assign part_rem  = rem_q;
  assign dvd_hold  = dvd_q;
  assign dvs_hold  = dvs_q;
  assign mode_hold = mode_q;

endmodule

// File: rtl/div_result.sv
module div_result
  import div_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             finish,
  input  logic [WIDTH-1:0] part_quo,
  input  logic [WIDTH-1:0] part_rem,
  input  logic [WIDTH-1:0] dvd_hold,
  input  logic [WIDTH-1:0] dvs_hold,
  input  div_mode_e        mode_hold,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder,
  output div_flags_t       flags
);

  logic             zero_dvs;
  logic             frac_ovf;
  logic             saturate;
  logic [WIDTH-1:0] quo_d, rem_d;
  div_flags_t       flags_d;

  logic [WIDTH-1:0] quo_q, rem_q;
  div_flags_t       flags_q;

  always_comb begin
    zero_dvs  = (dvs_hold == '0);
    frac_ovf  = (mode_hold == MODE_FRAC) && (dvs_hold <= dvd_hold);
    saturate  = zero_dvs | frac_ovf;
    quo_d     = saturate ? {WIDTH{1'b1}} : part_quo;
    rem_d     = saturate ? dvd_hold : part_rem;
    flags_d.z = (quo_d == '0);
    flags_d.v = frac_ovf;
    flags_d.c = zero_dvs;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_q   <= '0;
      rem_q   <= '0;
      flags_q <= '0;
    end else if (finish) begin
      quo_q   <= quo_d;
      rem_q   <= rem_d;
      flags_q <= flags_d;
    end
  end

  assign quotient  = quo_q;
  assign remainder = rem_q;
  assign flags     = flags_q;

endmodule

// File: rtl/div_unit.sv
module div_unit
  import div_pkg::*;
#(
  parameter int WIDTH   = 16,
  parameter int LATENCY = 41
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             frac_mode,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder,
  output logic             flag_z,
  output logic             flag_v,
  output logic             flag_c
);

  logic             load, step, finish;
  logic [WIDTH-1:0] part_quo, part_rem, dvd_hold, dvs_hold;
  div_mode_e        mode_hold;
  div_flags_t       flags;

  div_seq_ctrl #(.WIDTH(WIDTH), .LATENCY(LATENCY)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .load   (load),
    .step   (step),
    .finish (finish),
    .busy   (busy),
    .done   (done)
  );

  div_shift_core #(.WIDTH(WIDTH)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .step      (step),
    .frac_mode (frac_mode),
    .dividend  (dividend),
    .divisor   (divisor),
    .part_quo  (part_quo),
    .part_rem  (part_rem),
    .dvd_hold  (dvd_hold),
    .dvs_hold  (dvs_hold),
    .mode_hold (mode_hold)
  );

  div_result #(.WIDTH(WIDTH)) u_res (
    .clk       (clk),
    .rst_n     (rst_n),
    .finish    (finish),
    .part_quo  (part_quo),
    .part_rem  (part_rem),
    .dvd_hold  (dvd_hold),
    .dvs_hold  (dvs_hold),
    .mode_hold (mode_hold),
    .quotient  (quotient),
    .remainder (remainder),
    .flags     (flags)
  );

  assign flag_z = flags.z;
  assign flag_v = flags.v;
  assign flag_c = flags.c;

endmodule

// File: rtl/div_unit_check.sv
module div_unit_check #(
  parameter int WIDTH   = 16,
  parameter int LATENCY = 41
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             frac_mode,
  input logic [WIDTH-1:0] dividend,
  input logic [WIDTH-1:0] divisor,
  input logic             busy,
  input logic             done,
  input logic [WIDTH-1:0] quotient,
  input logic [WIDTH-1:0] remainder,
  input logic             flag_z,
  input logic             flag_v,
  input logic             flag_c
);

  localparam int CW = $clog2(LATENCY + 1);

  logic [CW-1:0]    cnt;
  logic             act;
  logic             mode_c;
  logic [WIDTH-1:0] dvd_c, dvs_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      act    <= 1'b0;
      mode_c <= 1'b0;
      dvd_c  <= '0;
      dvs_c  <= '0;
    end else if (start && !busy) begin
      cnt    <= '0;
      act    <= 1'b1;
      mode_c <= frac_mode;
      dvd_c  <= dividend;
      dvs_c  <= divisor;
    end else if (done) begin
      act <= 1'b0;
    end else if (act && cnt != CW'(LATENCY)) begin
      cnt <= cnt + 1'b1;
    end
  end

  assert_done_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (act && cnt == CW'(LATENCY)));

  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_not_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_int_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !mode_c) |-> !flag_v);

  assert_zero_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (flag_z == (quotient == '0)));

  assert_frac_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode_c && dvs_c <= dvd_c) |-> (flag_v && quotient == '1 && remainder == dvd_c));

  assert_zero_divisor_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (flag_c == (dvs_c == '0)));

  assert_busy_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));

  assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(quotient) && $stable(remainder)));

endmodule

bind div_unit div_unit_check #(.WIDTH(WIDTH), .LATENCY(LATENCY)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .frac_mode (frac_mode),
  .dividend  (dividend),
  .divisor   (divisor),
  .busy      (busy),
  .done      (done),
  .quotient  (quotient),
  .remainder (remainder),
  .flag_z    (flag_z),
  .flag_v    (flag_v),
  .flag_c    (flag_c)
);

// File: tb/div_unit_bench.sv
`timescale 1ns/1ps
module div_unit_bench;

  localparam int W   = 16;
  localparam int LAT = 41;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start;
  logic         frac_mode;
  logic [W-1:0] dividend, divisor;
  logic         busy, done;
  logic [W-1:0] quotient, remainder;
  logic         flag_z, flag_v, flag_c;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  div_unit u_div_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .frac_mode(frac_mode),
    .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
    .quotient(quotient), .remainder(remainder),
    .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      finish_run();
    end
  end

  // independent reference model
  function automatic void model(input logic [W-1:0] d, input logic [W-1:0] x,
                                input logic fr,
                                output logic [W-1:0] q, output logic [W-1:0] r,
                                output logic z, output logic v, output logic c);
    logic [31:0] num;
    c = (x == 0);
    v = fr && (x <= d);
    if (c || v) begin
      q = '1;
      r = d;
    end else begin
      num = fr ? {d, 16'h0000} : {16'h0000, d};
      q = W'(num / {16'h0, x});
      r = W'(num % {16'h0, x});
    end
    z = (q == 0);
  endfunction

  // run one divide; optionally poke a start with other operands mid-way
  task automatic run_div(input logic [W-1:0] d, input logic [W-1:0] x,
                         input logic fr, input bit poke);
    logic [W-1:0] eq, er;
    logic ez, ev, ec;
    int bad_cycle;
    string rq;
    model(d, x, fr, eq, er, ez, ev, ec);
    rq = fr ? "R2" : "R1";
    @(negedge clk);
    start = 1'b1; dividend = d; divisor = x; frac_mode = fr;
    @(posedge clk); #1;
    start = 1'b0;
    dividend = ~d; divisor = x ^ 16'h5a5a; frac_mode = ~fr;
    bad_cycle = 0;
    for (int i = 1; i <= LAT; i++) begin
      if (poke && i == 10) begin
        start = 1'b1; dividend = 16'h1234; divisor = 16'h0003; frac_mode = 1'b0;
      end
      if (poke && i == 11) start = 1'b0;
      @(posedge clk); #1;
      if (i < LAT) begin
        if (done !== 1'b0 || busy !== 1'b1) bad_cycle = i;
      end else begin
        if (done !== 1'b1 || busy !== 1'b0) bad_cycle = i;
      end
    end
    check(poke ? "R7" : "R3", "done at 41 cycles (bad cycle index)", bad_cycle, 0);
    if (!(x == 0) && !(fr && x <= d)) begin
      check(rq, "quotient", quotient, eq);
      check(rq, "remainder", remainder, er);
    end else begin
      check(ec ? "R6" : "R5", "saturated quotient", quotient, eq);
      check(ec ? "R6" : "R5", "returned dividend", remainder, er);
    end
    check("R4", "flag_z", flag_z, ez);
    check(fr ? "R5" : "R4", "flag_v", flag_v, ev);
    check("R6", "flag_c", flag_c, ec);
    @(posedge clk); #1;
    check("R3", "done pulse width", done, 1'b0);
  endtask

  initial begin
    logic [W-1:0] hq, hr;
    rst_n = 1'b0; start = 1'b0; frac_mode = 1'b0; dividend = '0; divisor = '0;
    void'($urandom(32'h2f61));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R8 reset values
    check("R8", "reset busy", busy, 0);
    check("R8", "reset done", done, 0);
    check("R8", "reset quotient", quotient, 0);
    check("R8", "reset remainder", remainder, 0);
    check("R8", "reset flags", {flag_z, flag_v, flag_c}, 3'b000);

    // directed corners
    run_div(16'd1000, 16'd7, 1'b0, 0);      // R1 basic
    run_div(16'd0, 16'd5, 1'b0, 0);         // R4 zero quotient
    run_div(16'd4, 16'd9, 1'b0, 0);         // R4 quotient 0, remainder 4
    run_div(16'hFFFF, 16'd1, 1'b0, 0);      // R1 max
    run_div(16'h1234, 16'd0, 1'b0, 0);      // R6 int zero divisor
    run_div(16'd1, 16'd2, 1'b1, 0);         // R2 0x8000
    run_div(16'hFFFE, 16'hFFFF, 1'b1, 0);   // R2 near one
    run_div(16'h4000, 16'h4000, 1'b1, 0);   // R5 equal -> overflow
    run_div(16'h8000, 16'h0123, 1'b1, 0);   // R5 divisor below dividend
    run_div(16'h00AB, 16'd0, 1'b1, 0);      // R6 frac zero divisor
    run_div(16'd5000, 16'd13, 1'b0, 1);     // R7 start while busy ignored

    // R8 hold: results stay put after done
    hq = quotient; hr = remainder;
    dividend = 16'h0777; divisor = 16'h0002;
    repeat (5) @(posedge clk);
    #1;
    check("R8", "quotient held", quotient, hq);
    check("R8", "remainder held", remainder, hr);
    check("R8", "done stays low", done, 0);

    // constrained random
    for (int k = 0; k < 80; k++) begin
      logic [W-1:0] d, x;
      logic fr;
      d  = W'($urandom);
      x  = W'($urandom);
      fr = 1'($urandom);
      case ($urandom % 4)
        0: x = W'($urandom % 16);
        1: if (fr && x <= d) begin d = x >> 1; end
        default: ;
      endcase
      run_div(d, x, fr, (k % 17) == 5);
    end

    finish_run();
  end

endmodule